// File: doc/BRIEF.md
# Serial Flash Command Register Front-End

This block is the software-facing half of a serial NOR flash controller. Software fills an opcode register, an address register and a word-wide data buffer over a simple 32-bit register bus. It then writes the command configuration word. If that word has its start bit set, the block hands a command descriptor to a separate serial sequencer, which drives the flash pins and signals when the command has finished.

The start bit reads back as 1 for as long as the command is in flight, so software can poll for completion. The sequencer reports failures as single-cycle pulses, and the block latches them in a status register until software clears them. The sequencer reaches the data buffer one byte at a time through its own port. Byte 0 of a transfer sits in the low lane of buffer word 0. The buffer holds 64 words when the version parameter is 0x351 and 16 words for any other value.

The bus has no byte enables. Every access is a full word, and read data appears one clock after the read request.

Top module: `flash_cmd_frontend`

## Requirements
- R1: Offset 0x1F8 reads the VERSION parameter. The buffer holds 64 words when VERSION is 0x351 and 16 words otherwise.
- R2: A write to the command config register (0x300) with bit 0 = 1 while idle produces a one-cycle `seq_launch` pulse, starting on the write's clock edge. At that point `seq_cfg`, `seq_opcode` and `seq_addr` carry the written config word, opcode and address.
- R3: Bit 0 of the config register reads 1 from the launching write until the clock edge that samples `seq_done`, and reads 0 after that. Bits 31:1 read back as written. A config write with bit 0 = 0 while idle stores bits 31:1 and launches nothing.
- R4: A config write while a command is busy is ignored: there is no launch, and the register keeps its value.
- R5: A `seq_err_prog` pulse sets status bit 2 and a `seq_err_prot` pulse sets status bit 5 (status register at 0x120). Both bits stay set until cleared, and all other status bits read 0.
- R6: A write to the clear register (0x12C) clears every status bit whose matching write-data bit is 1, so 0xFF clears all of them. The clear register reads 0.
- R7: A status set pulse and a clear write in the same cycle leave that bit set.
- R8: Buffer word i sits at 0x400 + 4·i and reads back what was written. Byte n on the sequencer byte port is bits 8·(n mod 4)+7 : 8·(n mod 4) of word n/4.
- R9: A sequencer byte write changes only its own byte lane, and the change is visible to a later bus read.
- R10: Reads from unmapped or misaligned offsets, including offsets past the end of the buffer, return 0. Writes to them change nothing.
- R11: The opcode register (0x308) and the address register (0x30C) read back as written.
- R12: After reset: not busy, no launch, config register and status register both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the request |
| seq_launch | output | 1 | One-cycle command start to the sequencer |
| seq_cfg | output | 32 | Command config word (bit 0 = busy) |
| seq_opcode | output | 32 | Opcode register |
| seq_addr | output | 32 | Address register |
| seq_done | input | 1 | Command complete pulse |
| seq_err_prog | input | 1 | Page program failure pulse |
| seq_err_prot | input | 1 | Protected address access pulse |
| seq_byte_idx | input | log2(4·words) | Byte index into the buffer (8 by default) |
| seq_byte_we | input | 1 | Sequencer byte write enable |
| seq_byte_wdata | input | 8 | Sequencer byte write data |
| seq_byte_rd | output | 8 | Buffer byte at seq_byte_idx |
| cmd_busy | output | 1 | Command in flight |

## Verification
The bench drives a config write while a command is still busy. A design that let that write through would start a second command, or it would corrupt the descriptor while the sequencer is still using it. The bench also lands a set pulse and a clear-all write in the same cycle; a design that gave the clear priority would lose the error. It probes the word just past the end of the 16-word buffer, on both a 16-word instance and a 64-word instance, which exposes a depth that does not follow the version value. It also writes single bytes into the middle of a word and checks that they land in the right lane, which catches reversed lane ordering.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned ST_W  = 8;

    localparam logic [31:0] OFS_VERSION  = 32'h0000_01F8;
    localparam logic [31:0] OFS_STATUS   = 32'h0000_0120;
    localparam logic [31:0] OFS_CLEAR    = 32'h0000_012C;
    localparam logic [31:0] OFS_CFG      = 32'h0000_0300;
    localparam logic [31:0] OFS_OPCODE   = 32'h0000_0308;
    localparam logic [31:0] OFS_ADDR     = 32'h0000_030C;
    localparam logic [31:0] OFS_BUF_BASE = 32'h0000_0400;

    localparam int unsigned ST_PROG_BIT = 2;
    localparam int unsigned ST_PROT_BIT = 5;

    localparam logic [31:0] LARGE_BUF_VERSION = 32'h0000_0351;

    function automatic int unsigned buf_words_for(input logic [31:0] ver);
        return (ver == LARGE_BUF_VERSION) ? 64 : 16;
    endfunction

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_VERSION,
        SEL_STATUS,
        SEL_CLEAR,
        SEL_CFG,
        SEL_OPCODE,
        SEL_ADDR,
        SEL_BUF
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] opc;
        logic [REG_W-1:0] adr;
        logic             busy;
        logic             launch;
    } cmd_state_t;

endpackage

// File: rtl/fcf_addr_decode.sv
module fcf_addr_decode
    import fcf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BUF_WORDS = 16,
    parameter int unsigned IDX_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  buf_idx
);

    localparam logic [31:0] BUF_END = OFS_BUF_BASE + 32'(4 * BUF_WORDS);

    logic [31:0] a32;

    assign a32 = 32'(addr);

    always_comb begin
        sel     = SEL_NONE;
        buf_idx = IDX_W'((a32 - OFS_BUF_BASE) >> 2);
        if (a32[1:0] == 2'b00) begin
            if (a32 == OFS_VERSION) begin
                sel = SEL_VERSION;
            end else if (a32 == OFS_STATUS) begin
                sel = SEL_STATUS;
            end else if (a32 == OFS_CLEAR) begin
                sel = SEL_CLEAR;
            end else if (a32 == OFS_CFG) begin
                sel = SEL_CFG;
            end else if (a32 == OFS_OPCODE) begin
                sel = SEL_OPCODE;
            end else if (a32 == OFS_ADDR) begin
                sel = SEL_ADDR;
            end else if (a32 >= OFS_BUF_BASE && a32 < BUF_END) begin
                sel = SEL_BUF;
            end
        end
    end

endmodule

// File: rtl/fcf_cmd_ctrl.sv
module fcf_cmd_ctrl
    import fcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             opc_we,
    input  logic             adr_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             seq_done,
    output logic [REG_W-1:0] cfg_rd,
    output logic [REG_W-1:0] opc_rd,
    output logic [REG_W-1:0] adr_rd,
    output logic             busy,
    output logic             launch
);

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.launch = 1'b0;
        if (st_q.busy && seq_done) begin
            st_d.busy = 1'b0;
        end
        if (cfg_we && !st_q.busy) begin
            st_d.cfg = {wdata[REG_W-1:1], 1'b0};
            if (wdata[0]) begin
                st_d.busy   = 1'b1;
                st_d.launch = 1'b1;
            end
        end
        if (opc_we) begin
            st_d.opc = wdata;
        end
        if (adr_we) begin
            st_d.adr = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rd = {st_q.cfg[REG_W-1:1], st_q.busy};
    assign opc_rd = st_q.opc;
    assign adr_rd = st_q.adr;
    assign busy   = st_q.busy;
    assign launch = st_q.launch;

endmodule

// File: rtl/fcf_irq_status.sv
module fcf_irq_status
    import fcf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_prog,
    input  logic            set_prot,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_mask,
    output logic [ST_W-1:0] status
);

    logic [ST_W-1:0] st_d, st_q;
    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] clr_vec;

    always_comb begin
        set_vec              = '0;
        set_vec[ST_PROG_BIT] = set_prog;
        set_vec[ST_PROT_BIT] = set_prot;
        clr_vec              = clr_we ? clr_mask : '0;
        st_d                 = (st_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q;

endmodule

// File: rtl/fcf_data_buf.sv
module fcf_data_buf #(
    parameter int unsigned WORDS      = 16,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned BYTE_IDX_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [IDX_W-1:0]      bus_idx,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rd,
    input  logic [BYTE_IDX_W-1:0] byte_idx,
    input  logic                  byte_we,
    input  logic [7:0]            byte_wdata,
    output logic [7:0]            byte_rd
);

    localparam int unsigned LANES  = 4;
    localparam int unsigned FLAT_W = WORDS * LANES * 8;

    logic [FLAT_W-1:0] flat_q;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [7:0] lane_d, lane_q;

            always_comb begin
                lane_d = lane_q;
                if (bus_we && bus_idx == IDX_W'(w)) begin
                    lane_d = bus_wdata[8*l +: 8];
                end
                if (byte_we && byte_idx == BYTE_IDX_W'(LANES * w + l)) begin
                    lane_d = byte_wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lane_q <= '0;
                end else begin
                    lane_q <= lane_d;
                end
            end

            assign flat_q[(LANES * w + l) * 8 +: 8] = lane_q;
        end
    end

    assign bus_rd  = flat_q[32 * bus_idx +: 32];
    assign byte_rd = flat_q[8 * byte_idx +: 8];

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
    import fcf_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter logic [31:0] VERSION = 32'h0000_0351,
    localparam int unsigned BUF_WORDS  = buf_words_for(VERSION),
    localparam int unsigned BYTE_IDX_W = $clog2(BUF_WORDS * 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  seq_launch,
    output logic [31:0]           seq_cfg,
    output logic [31:0]           seq_opcode,
    output logic [31:0]           seq_addr,
    input  logic                  seq_done,
    input  logic                  seq_err_prog,
    input  logic                  seq_err_prot,
    input  logic [BYTE_IDX_W-1:0] seq_byte_idx,
    input  logic                  seq_byte_we,
    input  logic [7:0]            seq_byte_wdata,
    output logic [7:0]            seq_byte_rd,
    output logic                  cmd_busy
);

    localparam int unsigned IDX_W = $clog2(BUF_WORDS);

    reg_sel_e         sel;
    logic [IDX_W-1:0] buf_idx;
    logic             wr_hit;
    logic             rd_hit;
    logic [31:0]      cfg_rd, opc_rd, adr_rd, buf_rd;
    logic [ST_W-1:0]  status_q;
    logic [31:0]      rdata_d, rdata_q;

    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;

    fcf_addr_decode #(
        .ADDR_W   (ADDR_W),
        .BUF_WORDS(BUF_WORDS),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .buf_idx(buf_idx)
    );

    fcf_cmd_ctrl u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (wr_hit && sel == SEL_CFG),
        .opc_we  (wr_hit && sel == SEL_OPCODE),
        .adr_we  (wr_hit && sel == SEL_ADDR),
        .wdata   (bus_wdata),
        .seq_done(seq_done),
        .cfg_rd  (cfg_rd),
        .opc_rd  (opc_rd),
        .adr_rd  (adr_rd),
        .busy    (cmd_busy),
        .launch  (seq_launch)
    );

    fcf_irq_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_prog(seq_err_prog),
        .set_prot(seq_err_prot),
        .clr_we  (wr_hit && sel == SEL_CLEAR),
        .clr_mask(bus_wdata[ST_W-1:0]),
        .status  (status_q)
    );

    fcf_data_buf #(
        .WORDS     (BUF_WORDS),
        .IDX_W     (IDX_W),
        .BYTE_IDX_W(BYTE_IDX_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (wr_hit && sel == SEL_BUF),
        .bus_idx   (buf_idx),
        .bus_wdata (bus_wdata),
        .bus_rd    (buf_rd),
        .byte_idx  (seq_byte_idx),
        .byte_we   (seq_byte_we),
        .byte_wdata(seq_byte_wdata),
        .byte_rd   (seq_byte_rd)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_hit) begin
            unique case (sel)
                SEL_VERSION: rdata_d = VERSION;
                SEL_STATUS:  rdata_d = 32'(status_q);
                SEL_CFG:     rdata_d = cfg_rd;
                SEL_OPCODE:  rdata_d = opc_rd;
                SEL_ADDR:    rdata_d = adr_rd;
                SEL_BUF:     rdata_d = buf_rd;
                default:     rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata  = rdata_q;
    assign seq_cfg    = cfg_rd;
    assign seq_opcode = opc_rd;
    assign seq_addr   = adr_rd;

endmodule

// File: rtl/fcf_checker.sv
module fcf_checker
    import fcf_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            seq_launch,
    input logic            cmd_busy,
    input logic            seq_done,
    input logic            seq_err_prog,
    input logic            seq_err_prot,
    input logic [31:0]     seq_cfg,
    input logic [ST_W-1:0] status
);

    localparam logic [ST_W-1:0] LIVE_MASK = ST_W'((1 << ST_PROG_BIT) | (1 << ST_PROT_BIT));

    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_launch |=> !seq_launch); // R2

    AST_LAUNCH_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_launch |-> cmd_busy); // R3

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy && !seq_done |=> cmd_busy); // R3

    AST_BUSY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy && seq_done |=> !cmd_busy); // R3

    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy && !seq_done |=> !seq_launch); // R4

    AST_DESC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy && !seq_launch |-> $stable(seq_cfg)); // R4

    AST_PROG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_prog |=> status[ST_PROG_BIT]); // R7

    AST_PROT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_prot |=> status[ST_PROT_BIT]); // R7

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~LIVE_MASK) == '0); // R5

endmodule

bind flash_cmd_frontend fcf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_launch  (seq_launch),
    .cmd_busy    (cmd_busy),
    .seq_done    (seq_done),
    .seq_err_prog(seq_err_prog),
    .seq_err_prot(seq_err_prot),
    .seq_cfg     (seq_cfg),
    .status      (status_q)
);

// File: tb/flash_cmd_frontend_tb.sv
module flash_cmd_frontend_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_big, rdata_small;
    logic        launch_big, launch_small;
    logic [31:0] cfg_big, opc_big, adr_big;
    logic [31:0] cfg_small, opc_small, adr_small;
    logic        seq_done = 1'b0;
    logic        err_prog = 1'b0;
    logic        err_prot = 1'b0;
    logic [7:0]  byte_idx = '0;
    logic        byte_we = 1'b0;
    logic [7:0]  byte_wdata = '0;
    logic [7:0]  byte_rd_big, byte_rd_small;
    logic        busy_big, busy_small;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] exp_s;
        bit          chk_s;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    logic     rd_cap = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_frontend u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_big),
        .seq_launch(launch_big), .seq_cfg(cfg_big),
        .seq_opcode(opc_big), .seq_addr(adr_big),
        .seq_done(seq_done), .seq_err_prog(err_prog), .seq_err_prot(err_prot),
        .seq_byte_idx(byte_idx), .seq_byte_we(byte_we),
        .seq_byte_wdata(byte_wdata), .seq_byte_rd(byte_rd_big),
        .cmd_busy(busy_big)
    );

    flash_cmd_frontend #(.VERSION(32'h0000_0350)) u_dut_small (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_small),
        .seq_launch(launch_small), .seq_cfg(cfg_small),
        .seq_opcode(opc_small), .seq_addr(adr_small),
        .seq_done(seq_done), .seq_err_prog(err_prog), .seq_err_prot(err_prot),
        .seq_byte_idx(byte_idx[5:0]), .seq_byte_we(byte_we),
        .seq_byte_wdata(byte_wdata), .seq_byte_rd(byte_rd_small),
        .cmd_busy(busy_small)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one scoreboard item per captured read
    always @(posedge clk) rd_cap <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (rd_cap) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", rdata_big, '0);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(rdata_big === it.exp, it.tag, rdata_big, it.exp);
                if (it.chk_s) begin
                    check(rdata_small === it.exp_s, {it.tag, " small"}, rdata_small, it.exp_s);
                end
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp,
                            input string tag);
        rd_item_t it;
        @(posedge clk); #2;
        it.exp = exp; it.exp_s = '0; it.chk_s = 1'b0; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #2;
        bus_sel = 1'b0;
    endtask

    task automatic bus_read2(input logic [11:0] a, input logic [31:0] exp,
                             input logic [31:0] exp_s, input string tag);
        rd_item_t it;
        @(posedge clk); #2;
        it.exp = exp; it.exp_s = exp_s; it.chk_s = 1'b1; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #2;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_done();
        @(posedge clk); #2; seq_done = 1'b1;
        @(posedge clk); #2; seq_done = 1'b0;
    endtask

    task automatic finish_run();
        repeat (4) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(busy_big == 1'b0, "R12 busy after reset", 32'(busy_big), 0);
        check(launch_big == 1'b0, "R12 launch after reset", 32'(launch_big), 0);
        bus_read(12'h300, 32'h0, "R12 cfg reset");
        bus_read(12'h120, 32'h0, "R12 status reset");

        // R1 version and depth
        bus_read2(12'h1F8, 32'h351, 32'h350, "R1 version");
        bus_write(12'h43C, 32'hA5A5_000F);
        bus_write(12'h440, 32'hA5A5_0010);
        bus_read2(12'h43C, 32'hA5A5_000F, 32'hA5A5_000F, "R1 word15");
        bus_read2(12'h440, 32'hA5A5_0010, 32'h0, "R1 word16");
        bus_write(12'h4FC, 32'hCAFE_003F);
        bus_read(12'h4FC, 32'hCAFE_003F, "R1 word63");

        // R11 opcode / address
        bus_write(12'h308, 32'h0000_0006);
        bus_write(12'h30C, 32'h0012_3400);
        bus_read(12'h308, 32'h0000_0006, "R11 opcode");
        bus_read(12'h30C, 32'h0012_3400, "R11 address");

        // R8 buffer words and byte lanes
        bus_write(12'h408, 32'h4433_2211);
        bus_read(12'h408, 32'h4433_2211, "R8 word2");
        for (int n = 0; n < 4; n++) begin
            byte_idx = 8'(8 + n);
            #1;
            check(byte_rd_big == 8'(8'h11 * (n + 1)), "R8 byte lane",
                  32'(byte_rd_big), 32'(8'h11 * (n + 1)));
        end

        // R9 sequencer byte write
        @(posedge clk); #2;
        byte_idx = 8'd9; byte_we = 1'b1; byte_wdata = 8'hEE;
        @(posedge clk); #2;
        byte_we = 1'b0;
        bus_read(12'h408, 32'h4433_EE11, "R9 byte write");

        // R2 launch
        bus_write(12'h300, 32'h0000_0389);
        @(negedge clk);
        check(launch_big == 1'b1, "R2 launch pulse", 32'(launch_big), 1);
        check(cfg_big == 32'h389, "R2 descriptor cfg", cfg_big, 32'h389);
        check(opc_big == 32'h6, "R2 descriptor opcode", opc_big, 32'h6);
        check(adr_big == 32'h0012_3400, "R2 descriptor address", adr_big, 32'h0012_3400);
        @(negedge clk);
        check(launch_big == 1'b0, "R2 launch single cycle", 32'(launch_big), 0);

        // R3 busy readback
        bus_read(12'h300, 32'h0000_0389, "R3 start reads 1 while busy");

        // R4 write while busy
        bus_write(12'h300, 32'h0000_0F01);
        @(negedge clk);
        check(launch_big == 1'b0, "R4 no relaunch", 32'(launch_big), 0);
        bus_read(12'h300, 32'h0000_0389, "R4 cfg unchanged");

        pulse_done();
        @(negedge clk);
        check(busy_big == 1'b0, "R3 busy cleared", 32'(busy_big), 0);
        bus_read(12'h300, 32'h0000_0388, "R3 start reads 0 after done");
        bus_write(12'h300, 32'h0000_0010);
        @(negedge clk);
        check(launch_big == 1'b0, "R3 no launch without start", 32'(launch_big), 0);
        bus_read(12'h300, 32'h0000_0010, "R3 cfg write no start");

        // R5 status
        @(posedge clk); #2; err_prog = 1'b1;
        @(posedge clk); #2; err_prog = 1'b0;
        bus_read(12'h120, 32'h04, "R5 prog bit");
        @(posedge clk); #2; err_prot = 1'b1;
        @(posedge clk); #2; err_prot = 1'b0;
        bus_read(12'h120, 32'h24, "R5 both bits sticky");

        // R6 clear
        bus_read(12'h12C, 32'h0, "R6 clear reads zero");
        bus_write(12'h12C, 32'h04);
        bus_read(12'h120, 32'h20, "R6 partial clear");
        bus_write(12'h12C, 32'hFF);
        bus_read(12'h120, 32'h00, "R6 clear all");

        // R7 set and clear together
        @(posedge clk); #2; err_prot = 1'b1;
        @(posedge clk); #2; err_prot = 1'b0;
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h12C; bus_wdata = 32'hFF;
        err_prog = 1'b1;
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_wr = 1'b0; err_prog = 1'b0;
        bus_read(12'h120, 32'h04, "R7 set wins over clear");

        // R10 unmapped
        bus_write(12'h400, 32'h1357_9BDF);
        bus_write(12'h402, 32'hFFFF_FFFF);
        bus_read(12'h400, 32'h1357_9BDF, "R10 misaligned write ignored");
        bus_read(12'h402, 32'h0, "R10 misaligned read zero");
        bus_read(12'h000, 32'h0, "R10 unmapped read zero");
        bus_write(12'h500, 32'hDEAD_BEEF);
        bus_read(12'h500, 32'h0, "R10 past buffer end");
        bus_write(12'h304, 32'hFFFF_FFFF);
        bus_read(12'h304, 32'h0, "R10 gap offset");
        bus_read(12'h300, 32'h0000_0010, "R10 neighbour untouched");

        repeat (3) @(posedge clk);
        check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 0);
        finish_run();
    end

endmodule